// File: doc/BRIEF.md
# Backlight Intensity Gating Controller

This block converts a requested backlight brightness, together with a handful of system conditions, into a serial-panel duty frame and two board-level enable outputs. The brightness is zeroed whenever the display is blanked, the supply is not good or the system is suspended. Under a low-battery condition it is clipped by a limit mask. It is then remapped so that every level above a knee value jumps upward by that same knee amount.

The low five bits of the remapped value travel to the panel inside an 8-bit frame that also carries the duty register address. Bit 5 leaves on a separate control output. The polarity of that output depends on whether the board also fits a dedicated on output. A second output is high whenever the result is nonzero. Every frame is followed one cycle later by a single-cycle pulse that informs a battery monitor of the load change.

A new frame is produced once after reset and then whenever any input changes. The last result stays visible on a read-back port between updates.

Top module: `bl_gate_ctrl`

## Requirements
- R1: While reset is held (synchronous, active low), `frame_vld_o`, `kick_o` and `on_o` are 0, `result_o` is 0, and `ctrl_o` equals `cfg_on_present_i`.
- R2: The gated value is 0 when `unblank_i` is 0, when `pwr_ok_i` is 0 or when `suspend_i` is 1; otherwise it is `level_i`.
- R3: When `batt_low_i` is 1, the gated value is bitwise ANDed with `limit_mask_i` before remapping; when it is 0 the mask has no effect.
- R4: A masked value greater than 16 has 16 added to it; a value of 16 or less passes unchanged. The result is 7 bits wide, so no result lies in 17..32.
- R5: `frame_o` bits 7:5 hold the duty register address 2 (binary 010) and bits 4:0 hold result bits 4:0. `frame_vld_o` is high for one cycle, in the cycle after the edge that sampled the inputs.
- R6: With each frame, `ctrl_o` becomes result bit 5 XOR `cfg_on_present_i`.
- R7: With each frame, `on_o` becomes 1 if the result is nonzero and 0 otherwise.
- R8: `kick_o` is a one-cycle pulse in the cycle after every `frame_vld_o` pulse.
- R9: A frame is issued at the first edge after reset and at every edge where any input differs from the values last captured; steady inputs issue no frame.
- R10: `result_o` holds the last result, and it and all other outputs stay unchanged between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| level_i | input | LVL_W | Requested brightness |
| limit_mask_i | input | LVL_W | Mask applied under low battery |
| unblank_i | input | 1 | 1 when the display is unblanked |
| pwr_ok_i | input | 1 | 1 when the panel power state is on |
| suspend_i | input | 1 | 1 while the system is suspended |
| batt_low_i | input | 1 | 1 when the battery is low |
| cfg_on_present_i | input | 1 | Board fits the on output; inverts the control output |
| frame_o | output | 8 | Duty register frame: address and low five result bits |
| frame_vld_o | output | 1 | One-cycle strobe for `frame_o` |
| on_o | output | 1 | Backlight on enable |
| ctrl_o | output | 1 | Result bit 5, with board polarity applied |
| kick_o | output | 1 | Battery monitor notification pulse |
| result_o | output | LVL_W+1 | Last computed result |

## Verification
The bench builds the block with its defaults: a 6-bit level, address 2 and a knee of 16. With these values, levels 16 and 17 straddle the remap step. Level 17 is the first value that sets bit 5 and level 63 wraps bit 5 back to 0, so both control polarities can be seen with bit 5 at 0 and at 1. Masks of 0x0F and 0x1F show the battery clip landing below and above the knee.

// File: rtl/bl_gate_ctrl.sv
module bl_gate_ctrl #(
  parameter int LVL_W     = 6,
  parameter int DUTY_ADDR = 2,
  parameter int KNEE      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] limit_mask_i,
  input  logic             unblank_i,
  input  logic             pwr_ok_i,
  input  logic             suspend_i,
  input  logic             batt_low_i,
  input  logic             cfg_on_present_i,
  output logic [7:0]       frame_o,
  output logic             frame_vld_o,
  output logic             on_o,
  output logic             ctrl_o,
  output logic             kick_o,
  output logic [LVL_W:0]   result_o
);
  localparam int RES_W = LVL_W + 1;
  localparam int IN_W  = 2 * LVL_W + 5;

  logic [IN_W-1:0]  in_vec, in_q;
  logic             primed_q, upd;
  logic [LVL_W-1:0] gated, masked;
  logic [RES_W-1:0] remap;

  assign in_vec = {level_i, limit_mask_i, unblank_i, pwr_ok_i,
                   suspend_i, batt_low_i, cfg_on_present_i};
  assign upd    = !primed_q || (in_vec != in_q);

  assign gated  = (unblank_i && pwr_ok_i && !suspend_i) ? level_i : '0;
  assign masked = batt_low_i ? (gated & limit_mask_i) : gated;
  assign remap  = (RES_W'(masked) > RES_W'(KNEE)) ? RES_W'(masked) + RES_W'(KNEE)
                                                  : RES_W'(masked);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed_q    <= 1'b0;
      in_q        <= '0;
      result_o    <= '0;
      frame_o     <= '0;
      frame_vld_o <= 1'b0;
      kick_o      <= 1'b0;
      on_o        <= 1'b0;
      ctrl_o      <= cfg_on_present_i;
    end else begin
      frame_vld_o <= upd;
      kick_o      <= frame_vld_o;
      if (upd) begin
        primed_q <= 1'b1;
        in_q     <= in_vec;
        result_o <= remap;
        frame_o  <= {3'(DUTY_ADDR), remap[4:0]};
        on_o     <= |remap;
        ctrl_o   <= remap[5] ^ cfg_on_present_i;
      end
    end
  end

  p_zero_when_suspended_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld_o && $past(suspend_i) |-> result_o == '0);
  p_zero_when_blanked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld_o && !$past(unblank_i) |-> result_o == '0);
  p_no_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld_o |-> (result_o <= RES_W'(KNEE)) || (result_o > RES_W'(2 * KNEE)));
  p_polarity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld_o |-> ctrl_o == (result_o[5] ^ $past(cfg_on_present_i)));
  p_kick_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld_o |=> kick_o && !frame_vld_o);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld_o |-> $stable(result_o) && $stable(on_o) && $stable(frame_o));
endmodule

// File: tb/bl_gate_ctrl_tb.sv
module bl_gate_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] level = 6'd0, mask = 6'h3f;
  logic unb = 1'b1, pok = 1'b1, sus = 1'b0, bl = 1'b0, cfg = 1'b0;
  logic [7:0] frame;
  logic fvld, on, ctrl, kick;
  logic [6:0] res;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bl_gate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .level_i(level), .limit_mask_i(mask),
    .unblank_i(unb), .pwr_ok_i(pok), .suspend_i(sus), .batt_low_i(bl),
    .cfg_on_present_i(cfg), .frame_o(frame), .frame_vld_o(fvld), .on_o(on),
    .ctrl_o(ctrl), .kick_o(kick), .result_o(res));

  function automatic logic [6:0] model(input logic [5:0] lv, mk,
                                       input logic u, p, s, b);
    logic [6:0] v;
    v = (u && p && !s) ? {1'b0, lv} : 7'd0;
    if (b) v = v & {1'b0, mk};
    return (v > 7'd16) ? v + 7'd16 : v;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic check_frame(input string tag);
    logic [6:0] e;
    e = model(level, mask, unb, pok, sus, bl);
    chk({tag, " R9 strobe"}, int'(fvld), 1);
    chk({tag, " R10 result"}, int'(res), int'(e));
    chk({tag, " R5 frame"}, int'(frame), int'({3'b010, e[4:0]}));
    chk({tag, " R7 on"}, int'(on), int'(e != 0));
    chk({tag, " R6 ctrl"}, int'(ctrl), int'(e[5] ^ cfg));
  endtask

  task automatic apply(input logic [5:0] lv, mk, input logic u, p, s, b, c,
                       input string tag);
    @(negedge clk);
    level = lv; mask = mk; unb = u; pok = p; sus = s; bl = b; cfg = c;
    @(negedge clk);
    check_frame(tag);
    @(negedge clk);
    chk({tag, " R8 kick"}, int'(kick), 1);
    chk({tag, " R5 single strobe"}, int'(fvld), 0);
  endtask

  task automatic t_reset(input logic c);
    @(negedge clk);
    rst_n = 1'b0; cfg = c; level = 6'h20;
    @(negedge clk); @(negedge clk);
    chk("R1 frame_vld", int'(fvld), 0);
    chk("R1 kick", int'(kick), 0);
    chk("R1 on", int'(on), 0);
    chk("R1 result", int'(res), 0);
    chk("R1 ctrl idle", int'(ctrl), int'(c));
    rst_n = 1'b1;
    @(negedge clk);
    check_frame("R9 first after reset");
    @(negedge clk);
    chk("R8 kick after first", int'(kick), 1);
  endtask

  task automatic t_remap();
    apply(6'd0,  6'h3f, 1, 1, 0, 0, 0, "R4 zero");
    apply(6'd16, 6'h3f, 1, 1, 0, 0, 0, "R4 knee");
    chk("R4 knee value", int'(res), 16);
    apply(6'd17, 6'h3f, 1, 1, 0, 0, 0, "R4 above knee");
    chk("R4 17 to 33", int'(res), 33);
    apply(6'h2f, 6'h3f, 1, 1, 0, 0, 0, "R4 mid");
    apply(6'h3f, 6'h3f, 1, 1, 0, 0, 0, "R4 top");
    chk("R4 63 to 79", int'(res), 79);
  endtask

  task automatic t_gating();
    apply(6'h2a, 6'h3f, 0, 1, 0, 0, 0, "R2 blanked");
    chk("R2 blanked zero", int'(res), 0);
    apply(6'h2a, 6'h3f, 1, 0, 0, 0, 0, "R2 power off");
    chk("R2 power zero", int'(res), 0);
    apply(6'h2a, 6'h3f, 1, 1, 1, 0, 0, "R2 suspended");
    chk("R2 suspend zero", int'(res), 0);
    apply(6'h2a, 6'h3f, 1, 1, 0, 0, 0, "R2 all clear");
  endtask

  task automatic t_battery();
    apply(6'h3f, 6'h0f, 1, 1, 0, 1, 0, "R3 clip below knee");
    chk("R3 clip 0x0f", int'(res), 15);
    apply(6'h3f, 6'h1f, 1, 1, 0, 1, 0, "R3 clip above knee");
    chk("R3 clip 0x2f", int'(res), 47);
    apply(6'h3f, 6'h01, 1, 1, 0, 0, 0, "R3 mask ignored");
    chk("R3 no clip", int'(res), 79);
  endtask

  task automatic t_polarity();
    apply(6'd17, 6'h3f, 1, 1, 0, 0, 1, "R6 inverted bit5 set");
    chk("R6 inverted low", int'(ctrl), 0);
    apply(6'd5,  6'h3f, 1, 1, 0, 0, 1, "R6 inverted bit5 clear");
    chk("R6 inverted high", int'(ctrl), 1);
    apply(6'd0,  6'h3f, 1, 1, 0, 0, 1, "R7 off inverted");
  endtask

  task automatic t_steady();
    logic [6:0] keep;
    apply(6'h12, 6'h3f, 1, 1, 0, 0, 0, "R9 setup");
    keep = res;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R9 no strobe when steady", int'(fvld), 0);
      chk("R9 no kick when steady", int'(kick), 0);
      chk("R10 result held", int'(res), int'(keep));
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset(1'b0);
    t_remap();
    t_gating();
    t_battery();
    t_reset(1'b1);
    t_polarity();
    t_steady();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule